// File: doc/BRIEF.md
# Toeplitz-Split GF(2^m) Multiply-and-Add Hash Engine

This block accumulates a polynomial hash over a stream of m-bit blocks in the binary field GF(2)[x]/(x^m + e(x)), where deg e = DELTA is small. For each accepted block C_i it performs V ← H·V ⊕ C_i in a single clock. After the block marked last it performs one more multiply by H with no addend. The result is C1·H^n ⊕ C2·H^(n-1) ⊕ … ⊕ Cn·H, which is the authentication hash used by counter-mode authenticated encryption.

Multiplication by the fixed key H uses the reduced product matrix of H, split in two. The first part is a Toeplitz matrix, applied through recursive three-way component formation, a component-wise AND and a reconstruction network. The second part is a correction matrix with DELTA nonzero rows, applied through AND/XOR-tree row products. The key-dependent constants are computed by the user and loaded through a wide configuration write. These are the Toeplitz components and the correction rows.

A message is driven as follows. Load a key, pulse start, then present blocks with a valid flag and flag the final one. Read the hash when the done pulse arrives.

Top module: `gf_tmvp_mac`

## Requirements
- R1: During and after reset, before any other input, hash_o is 0 and done_o is 0.
- R2: A cycle with cfg_we_i high stores the Toeplitz components and the correction rows, clears the accumulator and abandons any message in progress. After that edge, hash_o is 0 and done_o is 0. A configuration write takes priority over start_i and over blocks.
- R3: start_i clears the accumulator, so hash_o reads 0 after that edge, and opens a message. A block presented in the same cycle as start_i is dropped.
- R4: In an open message, each cycle with blk_valid_i high loads H·V ⊕ blk_i into the accumulator at that edge. The first block after start_i therefore appears unchanged on hash_o.
- R5: H·V is the XOR of a Toeplitz product and a correction product. Bit c of cfg_cmf_i holds component c. Write c in base 3 with log2(M) digits, most significant digit first, where T = [[T1,T0],[T2,T1]] and the lower half of a vector holds its low-index bits. At each level, digit 0 pairs T0+T1 with the upper half of the vector, digit 1 pairs T1 with the XOR of both halves, and digit 2 pairs T1+T2 with the lower half. cfg_srow_i[i*M +: M] is correction row i (i < DELTA), and its bit j is the coefficient of v_j in output bit i.
- R6: When the block carrying blk_last_i is accepted, the next cycle multiplies the accumulator by H with no addend. Block inputs in that cycle are ignored. The resulting hash is the sum of C_i·H^(n-i+1) over the message.
- R7: done_o is high for exactly one cycle. It rises at the edge that stores the final product, which is the first edge after the one that accepted the last block.
- R8: Outside a message, hash_o holds its value until the next start_i or configuration write. Blocks presented outside a message are ignored and raise no done_o.
- R9: In an open message, a cycle with blk_valid_i low leaves the accumulator unchanged.
- R10: start_i during an open message discards the partial result and restarts. The hash then covers only the blocks after the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load key constants, clear accumulator |
| cfg_cmf_i | input | 3^log2(M) | Toeplitz matrix components of the key |
| cfg_srow_i | input | DELTA*M | Correction rows of the key |
| start_i | input | 1 | Open a new message |
| blk_valid_i | input | 1 | blk_i carries a block this cycle |
| blk_i | input | M | Message block |
| blk_last_i | input | 1 | Current block is the final one |
| hash_o | output | M | Accumulator / final hash |
| done_o | output | 1 | One-cycle pulse: hash_o holds the final hash |

## Verification
A single wrong component constant, a miswired digit in the formation masks or a wrong reconstruction term corrupts H·V. The error shows on hash_o at the edge after the first block that reaches the multiplier, and it keeps spreading through every later block. Keys with high-order bits set are used so that the correction rows carry nonzero terms, and each hash is compared with a bit-serial shift-and-reduce reference. A sequencing fault, such as a lost final multiply, an early or long done_o, or a block absorbed during idle or the final cycle, appears within one or two cycles as a wrong hash or a misplaced done pulse.

// File: rtl/gf_tmvp_pkg.sv
`timescale 1ns/1ps
package gf_tmvp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } mac_state_e;

  // number of components after full three-way splitting: 3^log2(m)
  function automatic int comp_count(input int m);
    int n;
    n = 1;
    for (int w = m; w > 1; w = w / 2) n = n * 3;
    return n;
  endfunction

endpackage

// File: rtl/gf_tmvp_cvf.sv
`timescale 1ns/1ps
module gf_tmvp_cvf
  import gf_tmvp_pkg::*;
#(
  parameter  int M     = 16,
  localparam int LOG_M = $clog2(M),
  localparam int K     = comp_count(M)
) (
  input  logic [M-1:0] vec_i,
  output logic [K-1:0] comp_o
);

  // set of vector bits XORed into component c
  function automatic logic [M-1:0] pick_mask(input int c);
    logic [M-1:0] mk;
    int rem, sub, h, dig;
    mk    = '0;
    mk[0] = 1'b1;
    rem   = c;
    sub   = K;
    h     = M;
    for (int l = 0; l < LOG_M; l++) begin
      sub = sub / 3;
      h   = h / 2;
      dig = rem / sub;
      rem = rem % sub;
      if (dig == 0)      mk = mk << h;
      else if (dig == 1) mk = mk | (mk << h);
    end
    return mk;
  endfunction

  for (genvar c = 0; c < K; c++) begin : g_comp
    localparam logic [M-1:0] SEL = pick_mask(c);
    assign comp_o[c] = ^(vec_i & SEL);
  end

endmodule

// File: rtl/gf_tmvp_recon.sv
`timescale 1ns/1ps
module gf_tmvp_recon
  import gf_tmvp_pkg::*;
#(
  parameter  int M     = 16,
  localparam int LOG_M = $clog2(M),
  localparam int K     = comp_count(M)
) (
  input  logic [K-1:0] comp_i,
  output logic [M-1:0] vec_o
);

  // components feeding output bit j: lower half takes digits 0,1; upper takes 1,2
  function automatic logic [K-1:0] hit_mask(input int j);
    logic [K-1:0] mk;
    logic hit;
    int rem, sub, h, dig, b;
    mk = '0;
    for (int c = 0; c < K; c++) begin
      hit = 1'b1;
      rem = c;
      sub = K;
      h   = M;
      for (int l = 0; l < LOG_M; l++) begin
        sub = sub / 3;
        h   = h / 2;
        dig = rem / sub;
        rem = rem % sub;
        b   = (j / h) % 2;
        if ((b == 0 && dig == 2) || (b == 1 && dig == 0)) hit = 1'b0;
      end
      mk[c] = hit;
    end
    return mk;
  endfunction

  for (genvar j = 0; j < M; j++) begin : g_out
    localparam logic [K-1:0] HIT = hit_mask(j);
    assign vec_o[j] = ^(comp_i & HIT);
  end

endmodule

// File: rtl/gf_tmvp_corr.sv
`timescale 1ns/1ps
module gf_tmvp_corr #(
  parameter int M     = 16,
  parameter int DELTA = 5
) (
  input  logic [M-1:0]       vec_i,
  input  logic [DELTA*M-1:0] rows_i,
  output logic [M-1:0]       corr_o
);

  for (genvar i = 0; i < M; i++) begin : g_row
    if (i < DELTA) begin : g_act
      assign corr_o[i] = ^(rows_i[i*M +: M] & vec_i);
    end else begin : g_zero
      assign corr_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/gf_tmvp_mac.sv
`timescale 1ns/1ps
module gf_tmvp_mac
  import gf_tmvp_pkg::*;
#(
  parameter  int M     = 16,
  parameter  int DELTA = 5,
  localparam int K     = comp_count(M)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [K-1:0]       cfg_cmf_i,
  input  logic [DELTA*M-1:0] cfg_srow_i,
  input  logic               start_i,
  input  logic               blk_valid_i,
  input  logic [M-1:0]       blk_i,
  input  logic               blk_last_i,
  output logic [M-1:0]       hash_o,
  output logic               done_o
);

  mac_state_e         state_q;
  logic [M-1:0]       acc_q;
  logic               done_q;
  logic [K-1:0]       cmf_q;
  logic [DELTA*M-1:0] srow_q;

  logic [K-1:0] cvf_w, comp_w;
  logic [M-1:0] tmvp_w, corr_w, prod_w;

  gf_tmvp_cvf #(.M(M)) u_cvf (
    .vec_i  (acc_q),
    .comp_o (cvf_w)
  );

  assign comp_w = cmf_q & cvf_w;

  gf_tmvp_recon #(.M(M)) u_recon (
    .comp_i (comp_w),
    .vec_o  (tmvp_w)
  );

  gf_tmvp_corr #(.M(M), .DELTA(DELTA)) u_corr (
    .vec_i  (acc_q),
    .rows_i (srow_q),
    .corr_o (corr_w)
  );

  assign prod_w = tmvp_w ^ corr_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      acc_q   <= '0;
      done_q  <= 1'b0;
      cmf_q   <= '0;
      srow_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (cfg_we_i) begin
        cmf_q   <= cfg_cmf_i;
        srow_q  <= cfg_srow_i;
        acc_q   <= '0;
        state_q <= ST_IDLE;
      end else if (start_i) begin
        acc_q   <= '0;
        state_q <= ST_RUN;
      end else begin
        unique case (state_q)
          ST_RUN: begin
            if (blk_valid_i) begin
              acc_q <= prod_w ^ blk_i;
              if (blk_last_i) state_q <= ST_FIN;
            end
          end
          ST_FIN: begin
            acc_q   <= prod_w;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign hash_o = acc_q;
  assign done_o = done_q;

endmodule

// File: rtl/gf_tmvp_mac_chk.sv
`timescale 1ns/1ps
module gf_tmvp_mac_chk
  import gf_tmvp_pkg::*;
#(
  parameter int M = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cfg_we_i,
  input logic         start_i,
  input logic         blk_valid_i,
  input logic [M-1:0] hash_o,
  input logic         done_o,
  input mac_state_e   state_q
);

  a_r2_cfg_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (hash_o == '0 && !done_o));

  a_r3_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !cfg_we_i) |=> (hash_o == '0 && !done_o));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_after_fin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FIN && !cfg_we_i && !start_i) |=> done_o);

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !cfg_we_i && !start_i) |=> ($stable(hash_o) && !done_o));

  a_r9_gap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !blk_valid_i && !cfg_we_i && !start_i) |=> $stable(hash_o));

endmodule

bind gf_tmvp_mac gf_tmvp_mac_chk #(.M(M)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .start_i     (start_i),
  .blk_valid_i (blk_valid_i),
  .hash_o      (hash_o),
  .done_o      (done_o),
  .state_q     (state_q)
);

// File: tb/gf_tmvp_mac_tb.sv
`timescale 1ns/1ps
module gf_tmvp_mac_tb;
  localparam int M = 16;
  localparam int D = 5;
  localparam int K = 81;
  localparam logic [M-1:0] E_LOW = 16'h002D;  // x^5+x^3+x^2+1

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, start = 1'b0, blk_valid = 1'b0, blk_last = 1'b0;
  logic [K-1:0]   cfg_cmf = '0;
  logic [D*M-1:0] cfg_srow = '0;
  logic [M-1:0]   blk = '0;
  logic [M-1:0]   hash;
  logic           done;

  int n_chk = 0, n_err = 0;
  logic [M-1:0] key_h = '0;
  logic [M-1:0] msg [16];
  int msg_len = 0;

  always #2 clk = ~clk;

  gf_tmvp_mac #(.M(M), .DELTA(D)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_cmf_i(cfg_cmf),
    .cfg_srow_i(cfg_srow), .start_i(start), .blk_valid_i(blk_valid),
    .blk_i(blk), .blk_last_i(blk_last), .hash_o(hash), .done_o(done)
  );

  task automatic chk(input logic ok, input string req, input logic [M-1:0] act, input logic [M-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [M-1:0] xtime(input logic [M-1:0] a);
    return a[M-1] ? ((a << 1) ^ E_LOW) : (a << 1);
  endfunction

  function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r = '0;
    for (int i = M - 1; i >= 0; i--) begin
      r = xtime(r);
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] ref_hash();
    logic [M-1:0] v = '0;
    for (int i = 0; i < msg_len; i++) v = gmul(v, key_h) ^ msg[i];
    return gmul(v, key_h);
  endfunction

  // derive Toeplitz components and correction rows of key h (R5)
  task automatic build_key(input logic [M-1:0] h);
    logic [M-1:0] cols [M];
    logic [2*M-2:0] dd, nd;
    logic [M-1:0] c;
    int n, rem, sub, hh, dig;
    c = h;
    for (int j = 0; j < M; j++) begin
      cols[j] = c;
      c = xtime(c);
    end
    dd = '0;
    for (int k = 0; k < 2*M-1; k++) begin
      if (k >= M - 1)  dd[k] = cols[2*M-2-k][M-1];
      else if (k >= D) dd[k] = cols[M-1][k];
      else             dd[k] = 1'b0;
    end
    for (int i = 0; i < D; i++)
      for (int j = 0; j < M; j++)
        cfg_srow[i*M+j] = cols[j][i] ^ dd[i-j+M-1];
    for (int ci = 0; ci < K; ci++) begin
      logic [2*M-2:0] cur;
      cur = dd; n = M; rem = ci; sub = K;
      while (n > 1) begin
        hh = n / 2; sub = sub / 3; dig = rem / sub; rem = rem % sub;
        nd = '0;
        for (int k = 0; k < 2*hh-1; k++) begin
          if (dig == 0)      nd[k] = cur[k] ^ cur[k+hh];
          else if (dig == 1) nd[k] = cur[k+hh];
          else               nd[k] = cur[k+hh] ^ cur[k+2*hh];
        end
        cur = nd; n = hh;
      end
      cfg_cmf[ci] = cur[0];
    end
  endtask

  task automatic load_key(input logic [M-1:0] h);
    key_h = h;
    build_key(h);
    @(negedge clk); cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    chk(hash == '0, "R2 key load clears hash", hash, '0);
    chk(done == 1'b0, "R2 no done after key load", {15'd0, done}, '0);
  endtask

  // one complete message; optional gap, junk during final cycle, block beside start
  task automatic run_msg(input string tag, input int gap_at, input bit junk_fin, input bit blk_on_start);
    logic [M-1:0] exp, held;
    exp = ref_hash();
    @(negedge clk);
    start = 1'b1;
    if (blk_on_start) begin blk_valid = 1'b1; blk = 16'hA5A5; blk_last = 1'b1; end
    @(negedge clk);
    start = 1'b0; blk_valid = 1'b0; blk_last = 1'b0;
    chk(hash == '0, {"R3 start clears ", tag}, hash, '0);
    for (int i = 0; i < msg_len; i++) begin
      blk_valid = 1'b1; blk = msg[i]; blk_last = (i == msg_len - 1);
      @(negedge clk);
      if (i == 0) chk(hash == msg[0], {"R4 first block loads ", tag}, hash, msg[0]);
      if (i == gap_at && i < msg_len - 1) begin
        blk_valid = 1'b0; held = hash;
        repeat (2) @(negedge clk);
        chk(hash == held, {"R9 gap holds ", tag}, hash, held);
      end
    end
    blk_valid = 1'b0; blk_last = 1'b0;
    chk(done == 1'b0, {"R7 no early done ", tag}, {15'd0, done}, '0);
    if (junk_fin) begin blk_valid = 1'b1; blk = 16'hFFFF; blk_last = 1'b1; end
    @(negedge clk);
    blk_valid = 1'b0; blk_last = 1'b0;
    chk(done == 1'b1, {"R7 done pulse ", tag}, {15'd0, done}, 16'd1);
    chk(hash == exp, {"R6 R5 hash value ", tag}, hash, exp);
    @(negedge clk);
    chk(done == 1'b0, {"R7 done one cycle ", tag}, {15'd0, done}, '0);
    chk(hash == exp, {"R8 hash held ", tag}, hash, exp);
  endtask

  task automatic t_reset();
    chk(hash == '0, "R1 reset hash", hash, '0);
    chk(done == 1'b0, "R1 reset done", {15'd0, done}, '0);
  endtask

  task automatic t_idle_ignore();
    logic [M-1:0] held;
    held = hash;
    @(negedge clk); blk_valid = 1'b1; blk = 16'h1234;
    @(negedge clk); blk = 16'h5678; blk_last = 1'b1;
    @(negedge clk); blk_valid = 1'b0; blk_last = 1'b0;
    chk(hash == held, "R8 idle blocks ignored", hash, held);
    @(negedge clk);
    chk(done == 1'b0, "R8 idle no done", {15'd0, done}, '0);
  endtask

  task automatic t_restart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; blk_valid = 1'b1; blk = 16'hBEEF;
    @(negedge clk); blk = 16'hCAFE;
    @(negedge clk); blk_valid = 1'b0;
    msg[0] = 16'h0F0F; msg[1] = 16'h7001; msg[2] = 16'h8421; msg_len = 3;
    run_msg("R10 restart", -1, 1'b0, 1'b0);
  endtask

  task automatic t_key_abort();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; blk_valid = 1'b1; blk = 16'h3C3C;
    @(negedge clk); blk_valid = 1'b0;
    load_key(16'h4C1D);
    @(negedge clk);
    chk(hash == '0, "R2 aborted message stays idle", hash, '0);
    chk(done == 1'b0, "R2 abort no done", {15'd0, done}, '0);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();

    load_key(16'h8D31);
    msg[0] = 16'hC3A5; msg_len = 1;
    run_msg("single", -1, 1'b0, 1'b0);

    for (int i = 0; i < 6; i++) msg[i] = 16'h1F2E ^ (16'(i) * 16'h3D17);
    msg_len = 6;
    run_msg("gapped", 2, 1'b0, 1'b0);

    msg[0] = 16'hFFFF; msg[1] = 16'h8000; msg[2] = 16'h0001; msg[3] = 16'hA0A0; msg_len = 4;
    run_msg("R6 fin junk", -1, 1'b1, 1'b0);

    t_idle_ignore();

    msg[0] = 16'h1357; msg[1] = 16'h2468; msg_len = 2;
    run_msg("R3 start block dropped", -1, 1'b0, 1'b1);

    t_restart();

    load_key(16'h0001);
    msg[0] = 16'h1111; msg[1] = 16'h2222; msg[2] = 16'h4448; msg_len = 3;
    run_msg("R5 unit key", -1, 1'b0, 1'b0);

    load_key(16'h8000);
    for (int i = 0; i < 5; i++) msg[i] = 16'hF00D + 16'(i) * 16'h1111;
    msg_len = 5;
    run_msg("R5 top-bit key", 0, 1'b0, 1'b0);

    t_key_abort();

    msg[0] = 16'h7777; msg[1] = 16'h8001; msg_len = 2;
    run_msg("R5 new key", -1, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule